// File: doc/BRIEF.md
# Peripheral Bus Timeout Monitor

This block watches accesses on an on-chip peripheral bus and forces an error termination on any access that runs too long. An access opens when any bit of the peripheral select vector is asserted. From that cycle the monitor counts system clock cycles for as long as the addressed peripheral holds its transfer-wait line high. If the wait line drops first, the access ends normally and a one-cycle done pulse is issued. If the count reaches the programmed limit first, the monitor issues a one-cycle error pulse and closes the access.

A 32-bit control word sets the behaviour. It holds an enable bit and a 3-bit limit code. The limit is a power of two from 8 to 1024 cycles. A larger code gives a shorter limit. Only the low four bits are stored. After reset the monitor is enabled with its longest limit. Software chooses a limit that is longer than the response time of the slowest peripheral.

Top module: `pbus_timeout_monitor`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x0000_0008: the monitor is enabled and the limit code is 000.
- R2: A write stores bits 3:0 of `ctl_wdata`. Bit 3 is the enable and bits 2:0 are the limit code. Bits 31:4 always read as zero, and writing them has no effect.
- R3: The limit code c selects a limit of L = 1024 >> c cycles. Code 000 gives 1024 and code 111 gives 8. When an access keeps `xfer_wait` high, `err_term` is high in the cycle after the L-th rising edge, counted from the first edge at which a select bit is seen.
- R4: Counting starts when any single bit of `periph_sel` is asserted, whatever its index.
- R5: When `xfer_wait` is low at a rising edge during an open access, `cycle_done` is high for the next cycle and no error is raised. The count then restarts from zero for the next access.
- R6: If `xfer_wait` drops at the same edge at which the limit is reached, the access ends normally. `cycle_done` rises and `err_term` stays low.
- R7: While the enable bit is 0, `err_term` never rises, however long the access lasts. The access still ends normally when `xfer_wait` drops.
- R8: `err_term` is a single-cycle pulse, and it is never high together with `cycle_done`.
- R9: A control write during an open access takes effect from the cycle after the write edge and does not reset the running count. If the count is already at or past the new limit, the error fires at the next edge.
- R10: While no access is open and no select bit is asserted, `xfer_wait` is ignored: neither `cycle_done` nor `err_term` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| periph_sel | input | N_PERIPH | Peripheral select vector; any set bit opens an access |
| xfer_wait | input | 1 | High while the addressed peripheral extends the access |
| err_term | output | 1 | One-cycle error termination pulse |
| cycle_done | output | 1 | One-cycle normal termination pulse |

## Verification
The assertions check, on every cycle, that the error and done pulses are single and mutually exclusive. They also check that an error follows a cycle in which the monitor was enabled and the wait line was high, that a done pulse follows a cycle with the wait line low, and that the reserved readback bits stay zero. Only the bench's scenarios can show the cycle-exact limit for each of the eight codes, that each select bit opens an access, the tie between limit and wait release, the effect of a write in the middle of an access, and the reset readback.

// File: rtl/pbm_pkg.sv
// Package: shared constants and the control field layout for the monitor.
// Assumes: the limit code is CODE_W bits and the enable sits just above it.
package pbm_pkg;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned EN_BIT = CODE_W;
    localparam int unsigned CTL_W  = CODE_W + 1;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{en: 1'b1, code: '0};
endpackage

// File: rtl/pbm_ctrl_reg.sv
// Module: control word storage and readback.
// Holds the enable and limit code. Reserved bits are dropped on write and
// read back as zero. Assumes a write takes effect at the clock edge.
module pbm_ctrl_reg
    import pbm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctl_t              ctl
);
    localparam int unsigned PAD_W = DATA_W - CTL_W;

    ctl_t ctl_q;

    // Store the low control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (we) begin
            ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
        end
    end

    // Readback with the reserved bits forced to zero.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, ctl_q};
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/pbm_limit_decode.sv
// Module: turns the limit code into the last count value before an error.
// A code of c means a limit of 2**(LOG2_MAX-c). The output is that limit
// minus one. Assumes LOG2_MAX exceeds the largest code value.
module pbm_limit_decode
    import pbm_pkg::*;
#(
    parameter int unsigned LOG2_MAX = 10
) (
    input  logic [CODE_W-1:0]   code,
    output logic [LOG2_MAX-1:0] last_cnt
);
    // An all-ones value shifted right by the code is 2**(LOG2_MAX-c)-1.
    always_comb begin
        last_cnt = {LOG2_MAX{1'b1}} >> code;
    end
endmodule

// File: rtl/pbm_counter.sv
// Module: access tracking, cycle counting and the two termination pulses.
// An access opens on any select bit and stays open until the wait line is low
// at an edge (normal end) or the count reaches the limit (error end). Normal
// end wins a tie. The counter saturates when the monitor is disabled.
module pbm_counter #(
    parameter int unsigned N_PERIPH = 4,
    parameter int unsigned LOG2_MAX = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] sel,
    input  logic                wait_i,
    input  logic                en,
    input  logic [LOG2_MAX-1:0] last_cnt,
    output logic                err_o,
    output logic                done_o
);
    logic                busy_q;
    logic [LOG2_MAX-1:0] cnt_q;
    logic                active;
    logic                at_limit;

    // The access is open if it was already running or a select appears now.
    always_comb begin
        active   = busy_q | (|sel);
        at_limit = en && (cnt_q >= last_cnt);
    end

    // Advance the count and raise the termination pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            err_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            err_o  <= 1'b0;
            done_o <= 1'b0;
            if (!active) begin
                cnt_q <= '0;
            end else if (!wait_i) begin
                done_o <= 1'b1;
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (at_limit) begin
                err_o  <= 1'b1;
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                busy_q <= 1'b1;
                if (cnt_q != {LOG2_MAX{1'b1}}) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pbus_timeout_monitor.sv
// Module: top level of the peripheral bus timeout monitor.
// Joins the control word, the limit decoder and the counter. Assumes the
// select vector is already decoded from the address and that the master
// handles the error pulse.
module pbus_timeout_monitor
    import pbm_pkg::*;
#(
    parameter int unsigned N_PERIPH = 4,
    parameter int unsigned LOG2_MAX = 10,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [DATA_W-1:0]   ctl_wdata,
    output logic [DATA_W-1:0]   ctl_rdata,
    input  logic [N_PERIPH-1:0] periph_sel,
    input  logic                xfer_wait,
    output logic                err_term,
    output logic                cycle_done
);
    ctl_t                ctl;
    logic                mon_en;
    logic [LOG2_MAX-1:0] last_cnt;

    pbm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .rdata (ctl_rdata),
        .ctl   (ctl)
    );

    pbm_limit_decode #(.LOG2_MAX(LOG2_MAX)) u_dec (
        .code     (ctl.code),
        .last_cnt (last_cnt)
    );

    assign mon_en = ctl.en;

    pbm_counter #(.N_PERIPH(N_PERIPH), .LOG2_MAX(LOG2_MAX)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (periph_sel),
        .wait_i   (xfer_wait),
        .en       (mon_en),
        .last_cnt (last_cnt),
        .err_o    (err_term),
        .done_o   (cycle_done)
    );
endmodule

// File: rtl/pbm_checker.sv
// Module: protocol checks for the timeout monitor, bound to the top.
// Assumes the top exposes its internal enable as mon_en.
module pbm_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ctl_rdata,
    input logic              xfer_wait,
    input logic              err_term,
    input logic              cycle_done,
    input logic              mon_en
);
    assert_single_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_term |=> !err_term);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_term && cycle_done));

    assert_err_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_term |-> $past(mon_en));

    assert_tie_normal_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_term |-> $past(xfer_wait));

    assert_done_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> !$past(xfer_wait));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[DATA_W-1:4] == '0);
endmodule

bind pbus_timeout_monitor pbm_checker #(.DATA_W(DATA_W)) u_pbm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_rdata  (ctl_rdata),
    .xfer_wait  (xfer_wait),
    .err_term   (err_term),
    .cycle_done (cycle_done),
    .mon_en     (mon_en)
);

// File: tb/test_pbus_timeout_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
module test_pbus_timeout_monitor;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [N-1:0] periph_sel = '0;
    logic        xfer_wait = 1'b0;
    logic        err_term;
    logic        cycle_done;

    int n_checks = 0;
    int n_errs   = 0;
    bit done_all = 1'b0;

    pbus_timeout_monitor #(.N_PERIPH(N)) i_pbus_timeout_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .periph_sel (periph_sel),
        .xfer_wait  (xfer_wait),
        .err_term   (err_term),
        .cycle_done (cycle_done)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [31:0] d);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic end_xfer();
        periph_sel = '0;
        xfer_wait = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset readback", ctl_rdata, 32'h0000_0008);
        check("R1 no err at reset", {31'b0, err_term}, 32'd0);
    endtask

    task automatic t_readback();
        write_ctl(32'hFFFF_FFF5);
        check("R2 reserved bits dropped", ctl_rdata, 32'h0000_0005);
        write_ctl(32'hA5A5_A5AE);
        check("R2 low bits stored", ctl_rdata, 32'h0000_000E);
    endtask

    task automatic t_limit(input int code, input int idx);
        int lim = 1024 >> code;
        write_ctl(32'h8 | code);
        periph_sel = '0;
        periph_sel[idx] = 1'b1;
        xfer_wait = 1'b1;
        repeat (lim - 1) @(negedge clk);
        check($sformatf("R3 no err before limit code %0d", code), {31'b0, err_term}, 32'd0);
        @(negedge clk);
        check($sformatf("R3 R4 err at limit code %0d sel %0d", code, idx), {31'b0, err_term}, 32'd1);
        end_xfer();
        check("R8 err single pulse", {31'b0, err_term}, 32'd0);
    endtask

    task automatic t_normal();
        write_ctl(32'h8 | 32'd6);
        periph_sel = 4'b0100;
        xfer_wait = 1'b1;
        repeat (5) @(negedge clk);
        xfer_wait = 1'b0;
        @(negedge clk);
        check("R5 done pulse", {30'b0, cycle_done, err_term}, 32'd2);
        periph_sel = '0;
        @(negedge clk);
        check("R5 done single", {31'b0, cycle_done}, 32'd0);
        periph_sel = 4'b0001;
        xfer_wait = 1'b1;
        repeat (15) @(negedge clk);
        check("R5 count restarted", {31'b0, err_term}, 32'd0);
        @(negedge clk);
        check("R5 full limit after restart", {31'b0, err_term}, 32'd1);
        end_xfer();
    endtask

    task automatic t_tie();
        write_ctl(32'hF);
        periph_sel = 4'b0010;
        xfer_wait = 1'b1;
        repeat (7) @(negedge clk);
        xfer_wait = 1'b0;
        @(negedge clk);
        check("R6 tie done", {30'b0, cycle_done, err_term}, 32'd2);
        end_xfer();
    endtask

    task automatic t_disabled();
        bit seen = 1'b0;
        write_ctl(32'h7);
        periph_sel = 4'b1000;
        xfer_wait = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (err_term) seen = 1'b1;
        end
        check("R7 no err when disabled", {31'b0, seen}, 32'd0);
        xfer_wait = 1'b0;
        @(negedge clk);
        check("R7 normal end when disabled", {31'b0, cycle_done}, 32'd1);
        end_xfer();
    endtask

    task automatic t_midwrite();
        write_ctl(32'h8);
        periph_sel = 4'b0001;
        xfer_wait = 1'b1;
        repeat (20) @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = 32'hF;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R9 old limit at write edge", {31'b0, err_term}, 32'd0);
        @(negedge clk);
        check("R9 new limit next edge", {31'b0, err_term}, 32'd1);
        end_xfer();
    endtask

    task automatic t_idle();
        bit seen = 1'b0;
        write_ctl(32'hF);
        periph_sel = '0;
        for (int i = 0; i < 20; i++) begin
            xfer_wait = i[0];
            @(negedge clk);
            if (cycle_done || err_term) seen = 1'b1;
        end
        check("R10 idle ignores wait", {31'b0, seen}, 32'd0);
        xfer_wait = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        for (int c = 0; c < 8; c++) t_limit(c, c % N);
        t_normal();
        t_tie();
        t_disabled();
        t_midwrite();
        t_idle();
        done_all = 1'b1;
    end

    initial begin
        fork
            wait (done_all);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errs++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule